// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the event sources of a UART into one interrupt line. Four sources are tracked: receive, transmit, receive timeout and modem status. The receive and transmit requests come from comparing the FIFO fill levels, supplied by the serial datapath, against two programmable thresholds. The modem-status event is any change of the CTS input after it has been synchronised to the local clock. Every source sets a sticky bit in a status register. Each bit is masked by its own enable in a control register, and the unmasked bits are ORed onto `irq_o`.

The same register file holds the control register, which also drives the UART enable and loopback outputs. It also provides a read-only flag register that reports CTS, transmitter busy, TX FIFO full and TX FIFO empty. Software reads the status register inside the interrupt handler and clears every latched bit with a single write of any value.

The register interface is a plain single-cycle port. A write takes effect on the clock edge where `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i`. There is no data stream through the block, so it has no valid/ready handshake.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is active and directly after it, the control register reads 0x00, the status register reads 0x00, `irq_o` is low, the receive threshold reads 1 and the transmit threshold reads 0.
- R2: The register addresses are 0 control, 1 status, 2 flags, 3 receive threshold and 4 transmit threshold. In the control register, bit 0 is the UART enable (driven on `uart_en_o`), bit 3 enables modem-status, bit 4 enables receive, bit 5 enables transmit, bit 6 enables receive-timeout and bit 7 is loopback (driven on `loopback_o`). Bits 1 and 2 always read 0.
- R3: Status bit 0 is modem status, bit 1 receive, bit 2 transmit and bit 3 receive timeout, and bits 7..4 read 0. A bit stays set after its source goes inactive, until it is cleared.
- R4: A write of any value to the status register clears all latched bits. A source that is active in the same cycle as the clear write is latched again, so its bit reads 1 on the next cycle.
- R5: `irq_o` is high exactly when some status bit is set together with its enable bit. A status bit whose enable is 0 does not raise `irq_o`.
- R6: The receive source is active when `rx_level_i` is nonzero and at least the receive threshold. With threshold 1, a single character raises it.
- R7: The transmit source is active when `tx_level_i` is at or below the transmit threshold.
- R8: After a two-stage synchroniser, a rising or a falling edge of `cts_i` sets status bit 0.
- R9: The flag register reads bit 0 = synchronised CTS, bit 3 = busy (`tx_level_i` nonzero or `tx_shifting_i` high), bit 5 = TX full (`tx_level_i` equals the FIFO depth) and bit 7 = TX empty (`tx_level_i` zero). The other bits read 0, and writes to the flag register have no effect.
- R10: A one-cycle pulse on `rx_timeout_i` sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| rx_level_i | input | LVL_W (5) | Receive FIFO fill count |
| tx_level_i | input | LVL_W (5) | Transmit FIFO fill count |
| tx_shifting_i | input | 1 | A character is in the transmit shifter |
| rx_timeout_i | input | 1 | Receive-timeout event pulse |
| cts_i | input | 1 | Asynchronous CTS line |
| irq_o | output | 1 | Combined interrupt |
| uart_en_o | output | 1 | UART enable from the control register |
| loopback_o | output | 1 | Loopback select from the control register |

## Verification
The clear write to the status register can land in the same cycle as a new source event. The bench provokes this in two ways. In the first, a receive-timeout pulse is driven in the very cycle of the clear write, and the status is expected to read only the timeout bit afterwards. In the second, the clear is written while the receive FIFO level still meets its threshold, and the receive bit must read set again one cycle later. A design that lets the clear override the new event loses the pulse, and the first case exposes it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int NSRC   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_FLAG = 3'd2,
    A_RXTH = 3'd3,
    A_TXTH = 3'd4
  } reg_addr_e;

  // control bit positions
  localparam int C_EN   = 0;
  localparam int C_MSIE = 3;
  localparam int C_RXIE = 4;
  localparam int C_TXIE = 5;
  localparam int C_RTIE = 6;
  localparam int C_LOOP = 7;
  localparam logic [7:0] CTRL_MASK = 8'hF9;

  // status bit positions
  localparam int S_MS  = 0;
  localparam int S_RX  = 1;
  localparam int S_TX  = 2;
  localparam int S_RTO = 3;

  // flag bit positions
  localparam int F_CTS    = 0;
  localparam int F_BUSY   = 3;
  localparam int F_TXFULL = 5;
  localparam int F_TXEMPT = 7;
endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
  parameter int LVL_W      = 5,
  parameter bit FILL_ABOVE = 1'b1
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             req_o
);
  generate
    if (FILL_ABOVE) begin : g_fill
      // receive style: enough characters waiting
      assign req_o = (level_i != '0) && (level_i >= thr_i);
    end else begin : g_drain
      // transmit style: FIFO has drained to the mark
      assign req_o = (level_i <= thr_i);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (clr_i ? '0 : stat_q) | src_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);

  // R4: after a clear only the sources of that cycle remain
  a_r4_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stat_q == $past(src_i)));

  // R3: without a clear no latched bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic              tx_shifting_i,
  input  logic              rx_timeout_i,
  input  logic              cts_i,
  output logic              irq_o,
  output logic              uart_en_o,
  output logic              loopback_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

  logic [7:0]       ctrl_q;
  logic [LVL_W-1:0] rx_thr_q, tx_thr_q;
  logic             cts_lvl, cts_edge;
  logic             rx_req, tx_req;
  logic [NSRC-1:0]  src, en, stat;
  logic             clr;
  logic [7:0]       flags;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 8'h00;
      rx_thr_q <= LVL_W'(1);
      tx_thr_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_e'(reg_addr_i))
        A_CTRL:  ctrl_q   <= reg_wdata_i & CTRL_MASK;
        A_RXTH:  rx_thr_q <= LVL_W'(reg_wdata_i);
        A_TXTH:  tx_thr_q <= LVL_W'(reg_wdata_i);
        default: ;
      endcase
    end
  end

  assign clr = reg_wr_i && (reg_addr_e'(reg_addr_i) == A_STAT);

  uart_irq_edge #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .async_i(cts_i),
    .level_o(cts_lvl), .edge_o(cts_edge)
  );

  uart_irq_thresh #(.LVL_W(LVL_W), .FILL_ABOVE(1'b1)) u_rx_thr (
    .level_i(rx_level_i), .thr_i(rx_thr_q), .req_o(rx_req)
  );

  uart_irq_thresh #(.LVL_W(LVL_W), .FILL_ABOVE(1'b0)) u_tx_thr (
    .level_i(tx_level_i), .thr_i(tx_thr_q), .req_o(tx_req)
  );

  always_comb begin
    src        = '0;
    src[S_MS]  = cts_edge;
    src[S_RX]  = rx_req;
    src[S_TX]  = tx_req;
    src[S_RTO] = rx_timeout_i;
    en         = '0;
    en[S_MS]   = ctrl_q[C_MSIE];
    en[S_RX]   = ctrl_q[C_RXIE];
    en[S_TX]   = ctrl_q[C_TXIE];
    en[S_RTO]  = ctrl_q[C_RTIE];
  end

  uart_irq_status #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .src_i(src), .clr_i(clr), .en_i(en),
    .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    flags           = 8'h00;
    flags[F_CTS]    = cts_lvl;
    flags[F_BUSY]   = (tx_level_i != '0) || tx_shifting_i;
    flags[F_TXFULL] = (tx_level_i == DEPTH_L);
    flags[F_TXEMPT] = (tx_level_i == '0);
  end

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_STAT:  reg_rdata_o = 8'(stat);
      A_FLAG:  reg_rdata_o = flags;
      A_RXTH:  reg_rdata_o = 8'(rx_thr_q);
      A_TXTH:  reg_rdata_o = 8'(tx_thr_q);
      default: reg_rdata_o = 8'h00;
    endcase
  end

  assign uart_en_o  = ctrl_q[C_EN];
  assign loopback_o = ctrl_q[C_LOOP];

  // R5: with every source enable low the line stays quiet
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_MSIE:C_MSIE] == 1'b0 && ctrl_q[C_RTIE:C_RXIE] == 3'b000) |-> !irq_o);

  // R6: threshold one reacts to a single character
  a_r6_thr_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr_q == LVL_W'(1) && rx_level_i != '0) |=> stat[S_RX]);

  // R8: any change of the synchronised CTS is latched
  a_r8_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_lvl != $past(cts_lvl)) |=> stat[S_MS]);

  // R2: reserved control bits never become set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 3'd0) |=> (ctrl_q[2:1] == 2'b00));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] rx_level = '0;
  logic [4:0] tx_level = 5'd5;
  logic       tx_shifting = 1'b0;
  logic       rx_timeout = 1'b0;
  logic       cts = 1'b0;
  logic       irq, uart_en, loopback;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_level_i(rx_level), .tx_level_i(tx_level), .tx_shifting_i(tx_shifting),
    .rx_timeout_i(rx_timeout), .cts_i(cts), .irq_o(irq),
    .uart_en_o(uart_en), .loopback_o(loopback)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); check("R1 ctrl", d, 8'h00);
    rd(3'd1, d); check("R1 status", d, 8'h00);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    idle(1);
    rd(3'd3, d); check("R1 rx threshold", d, 1);
    rd(3'd4, d); check("R1 tx threshold", d, 0);
    rd(3'd1, d); check("R1 status after reset", d, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(3'd0, 8'hFF);
    rd(3'd0, d); check("R2 ctrl reserved bits", d, 8'hF9);
    check("R2 uart_en", uart_en, 1);
    check("R2 loopback", loopback, 1);
    wr(3'd0, 8'h80);
    check("R2 uart_en off", uart_en, 0);
    check("R2 loopback kept", loopback, 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    rx_level = 5'd1;
    idle(1);
    rd(3'd1, d); check("R6 one char threshold 1", d, 8'h02);
    check("R5 masked no irq", irq, 0);
    wr(3'd0, 8'h10);
    check("R5 enabled irq", irq, 1);
    rx_level = 5'd0;
    idle(2);
    rd(3'd1, d); check("R3 sticky", d, 8'h02);
    wr(3'd1, 8'h5A);
    rd(3'd1, d); check("R4 clear", d, 8'h00);
    check("R5 irq drops", irq, 0);
    wr(3'd3, 8'd4);
    rx_level = 5'd3;
    idle(2);
    rd(3'd1, d); check("R6 below threshold", d, 8'h00);
    rx_level = 5'd4;
    idle(1);
    rd(3'd1, d); check("R6 at threshold", d, 8'h02);
    rx_level = 5'd0;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'd1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    wr(3'd4, 8'd2);
    tx_level = 5'd3;
    wr(3'd1, 8'h00);
    idle(1);
    rd(3'd1, d); check("R7 above threshold", d, 8'h00);
    tx_level = 5'd2;
    idle(1);
    rd(3'd1, d); check("R7 at threshold", d, 8'h04);
    wr(3'd0, 8'h20);
    check("R5 tx irq", irq, 1);
    tx_level = 5'd5;
    wr(3'd4, 8'd0);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_cts;
    logic [7:0] d;
    cts = 1'b1;
    idle(4);
    rd(3'd1, d); check("R8 rising edge", d, 8'h01);
    rd(3'd2, d); check("R9 cts flag", d[0], 1);
    wr(3'd1, 8'h00);
    idle(1);
    rd(3'd1, d); check("R8 no edge while steady", d, 8'h00);
    cts = 1'b0;
    idle(4);
    rd(3'd1, d); check("R8 falling edge", d, 8'h01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_flags;
    logic [7:0] d;
    tx_level = 5'd0;
    tx_shifting = 1'b0;
    rd(3'd2, d); check("R9 idle empty", d, 8'h80);
    tx_shifting = 1'b1;
    rd(3'd2, d); check("R9 shifting busy", d, 8'h88);
    tx_shifting = 1'b0;
    tx_level = 5'd16;
    rd(3'd2, d); check("R9 full", d, 8'h28);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); check("R9 write ignored", d, 8'h28);
    tx_level = 5'd5;
    wr(3'd1, 8'h00);
    rd(3'd0, d); check("R9 write left ctrl", d, 8'h00);
  endtask

  task automatic t_rto;
    logic [7:0] d;
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
    idle(2);
    rd(3'd1, d); check("R10 timeout latched", d, 8'h08);
    wr(3'd0, 8'h40);
    check("R10 timeout irq", irq, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    // clear and a timeout pulse in one cycle
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'hFF; reg_wr = 1'b1; rx_timeout = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; rx_timeout = 1'b0;
    rd(3'd1, d); check("R4 clear with pulse", d, 8'h08);
    wr(3'd1, 8'h00);
    // clear while receive level still meets threshold
    rx_level = 5'd2;
    idle(1);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R4 clear with active source", d, 8'h02);
    rx_level = 5'd0;
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R4 clear after source gone", d, 8'h00);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_ctrl();
    t_rx();
    t_tx();
    t_cts();
    t_flags();
    t_rto();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule